// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests from a non-maskable input, two active-low external lines and a parameterized set of on-chip peripheral lines. A single configuration register assigns each source a priority level. The same register selects, for each external line, whether it is sensed by level or by falling edge, and a source can be switched off through the same field.

Every cycle the block compares each request against the core's current two-bit mask, which arrives as an input. It then registers the strongest surviving request together with that source's index and level. Level 3 is used only by the non-maskable input, and the mask can never hold it back.

Edge-sensed requests are latched into a pending flag. The flag stays set until the core acknowledges that source by its index. The core writes and reads the register through a simple port. A hardware reset clears the register, and so does a software clear strobe.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request at level L is forwarded only when L is greater than or equal to `cur_mask`, except that level 3 is always forwarded. Under this rule mask 0 lets levels 0 to 3 through, mask 1 lets 1 to 3 through, mask 2 lets 2 to 3 through, and mask 3 lets only 3 through.
- R2: `nmi_req` (active high, level-sensed) is a level-3 source with index 0. It is forwarded under every mask value.
- R3: Each 2-bit priority field is decoded as follows: 00 means disabled, 01 means level 0, 10 means level 1 and 11 means level 2. A disabled source never requests and never latches a pending edge.
- R4: The register layout is as follows. External A has its priority in bits 1:0 and its trigger mode in bit 2. External B has its priority in bits 4:3 and its trigger mode in bit 5. Peripheral k has its priority in bits 11+2k:10+2k. A write with `cfg_we` takes effect at the next clock edge, and `cfg_rdata` shows the register at all times.
- R5: Bits 9:6 and every bit above the last peripheral field (bits 23:16 by default) read as zero. Writes to these bits have no effect.
- R6: The register is cleared by `rst_n` low and also by `soft_clr`. When `soft_clr` and `cfg_we` are high in the same cycle, `soft_clr` wins.
- R7: With trigger mode 0, an enabled external line requests for as long as its pin is low.
- R8: With trigger mode 1, a falling edge on an enabled external line sets a pending flag. The flag is cleared only by `ack_valid` with `ack_src` equal to that source's index (A is 1, B is 2). If a new edge and the acknowledge arrive in the same cycle, the edge wins.
- R9: Among the forwarded requests the highest level wins. Ties go to the lowest index, in the order non-maskable (0), external A (1), external B (2), peripheral k (3+k).
- R10: The outputs are registered. A level-sensed request shows on `irq_valid` one clock edge after it is sampled. A falling edge shows two edges after it is sampled: one edge latches the pending flag and the next registers the output.
- R11: When no request is forwarded, `irq_valid`, `irq_src` and `irq_level` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_clr | input | 1 | Software clear strobe for the configuration register |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | REG_W (24) | Register write data |
| cfg_rdata | output | REG_W (24) | Register read data |
| cur_mask | input | 2 | Core's current interrupt mask |
| nmi_req | input | 1 | Non-maskable request, active high |
| ext_a_n | input | 1 | External line A, active low |
| ext_b_n | input | 1 | External line B, active low |
| periph_req | input | NUM_PERIPH (3) | Peripheral requests, active high |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_src | input | IDX_W (3) | Index of the acknowledged source |
| irq_valid | output | 1 | A forwarded request is present |
| irq_src | output | IDX_W (3) | Index of the winning source |
| irq_level | output | 2 | Level of the winning source |

## Verification
The bench uses the defaults NUM_PERIPH=3 and REG_W=24. With these values there are six sources and a 3-bit index. The 24-bit register also leaves an upper byte of reserved bits that can be written and read back as zero. Three peripheral fields let every level from 0 to 2 be crossed with all four mask values on a single peripheral. The same fields also let ties at level 2 between two peripherals and at level 1 between the two external lines exercise the fixed ordering.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;

    typedef logic [1:0] lvl_t;

    localparam logic [1:0] FLD_OFF  = 2'b00;
    localparam lvl_t       LVL_TOP  = 2'd3;
    localparam int         EXT_NUM  = 2;
    localparam int         EXT_SPAN = 3;
    localparam int         PER_BASE = 10;

    // 01 -> 0, 10 -> 1, 11 -> 2 (00 handled as disabled by callers)
    function automatic lvl_t fld_level(input logic [1:0] fld);
        return fld - 2'd1;
    endfunction

    function automatic logic lvl_passes(input lvl_t lvl, input logic [1:0] mask);
        return (lvl == LVL_TOP) || (lvl >= mask);
    endfunction

    typedef struct packed {
        logic prev;
        logic pend;
    } edge_st_t;

endpackage

// File: rtl/irq_cfg_reg.sv
`timescale 1ns/1ps
module irq_cfg_reg #(
    parameter int REG_W      = 24,
    parameter int NUM_PERIPH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg
);
    import irq_prio_pkg::*;

    localparam int PER_TOP = PER_BASE + 2 * NUM_PERIPH;

    function automatic logic [REG_W-1:0] keep_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int b = 0; b < REG_W; b++) begin
            if (b < EXT_NUM * EXT_SPAN || (b >= PER_BASE && b < PER_TOP)) m[b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] WMASK = keep_bits();

    logic [REG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (soft_clr)  cfg_d = '0;
        else if (we)   cfg_d = wdata & WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/irq_ext_front.sv
`timescale 1ns/1ps
module irq_ext_front (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_n,
    input  logic [1:0] fld,
    input  logic       edge_mode,
    input  logic       ack_hit,
    output logic       req
);
    import irq_prio_pkg::*;

    edge_st_t st_d, st_q;
    logic     enabled;
    logic     fall;

    assign enabled = (fld != FLD_OFF);
    assign fall    = st_q.prev & ~pin_n;

    always_comb begin
        st_d.prev = pin_n;
        st_d.pend = st_q.pend;
        if (!enabled || !edge_mode) st_d.pend = 1'b0;
        else if (fall)              st_d.pend = 1'b1;
        else if (ack_hit)           st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, pend: 1'b0};
        else        st_q <= st_d;
    end

    assign req = enabled & (edge_mode ? st_q.pend : ~pin_n);

endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
    parameter int NSRC  = 6,
    parameter int IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      req,
    input  logic [NSRC-1:0][1:0] lvl,
    input  logic [1:0]           mask,
    output logic                 vld,
    output logic [IDX_W-1:0]     src,
    output logic [1:0]           lvl_o
);
    import irq_prio_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] src;
        lvl_t             lvl;
    } pick_st_t;

    pick_st_t pk_d, pk_q;

    always_comb begin
        pk_d = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && lvl_passes(lvl[i], mask) && (!pk_d.vld || lvl[i] > pk_d.lvl)) begin
                pk_d.vld = 1'b1;
                pk_d.src = IDX_W'(i);
                pk_d.lvl = lvl[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign vld   = pk_q.vld;
    assign src   = pk_q.src;
    assign lvl_o = pk_q.lvl;

endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
    parameter int NUM_PERIPH = 3,
    parameter int REG_W      = 24,
    parameter int IDX_W      = $clog2(3 + NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_clr,
    input  logic                  cfg_we,
    input  logic [REG_W-1:0]      cfg_wdata,
    output logic [REG_W-1:0]      cfg_rdata,
    input  logic [1:0]            cur_mask,
    input  logic                  nmi_req,
    input  logic                  ext_a_n,
    input  logic                  ext_b_n,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic                  ack_valid,
    input  logic [IDX_W-1:0]      ack_src,
    output logic                  irq_valid,
    output logic [IDX_W-1:0]      irq_src,
    output logic [1:0]            irq_level
);
    import irq_prio_pkg::*;

    localparam int NSRC     = 1 + EXT_NUM + NUM_PERIPH;
    localparam int EXT_IDX0 = 1;
    localparam int PER_IDX0 = 1 + EXT_NUM;

    logic [REG_W-1:0]       cfg;
    logic [NSRC-1:0]        req;
    logic [NSRC-1:0][1:0]   lvl;
    logic [EXT_NUM-1:0]     ext_n;

    assign ext_n = {ext_b_n, ext_a_n};

    irq_cfg_reg #(.REG_W(REG_W), .NUM_PERIPH(NUM_PERIPH)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg      (cfg)
    );

    assign req[0] = nmi_req;
    assign lvl[0] = LVL_TOP;

    for (genvar g = 0; g < EXT_NUM; g++) begin : g_ext
        logic [1:0] fld;
        logic       ack_hit;
        assign fld     = cfg[g*EXT_SPAN +: 2];
        assign ack_hit = ack_valid && (ack_src == IDX_W'(EXT_IDX0 + g));

        irq_ext_front u_front (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[g]),
            .fld       (fld),
            .edge_mode (cfg[g*EXT_SPAN + 2]),
            .ack_hit   (ack_hit),
            .req       (req[EXT_IDX0 + g])
        );
        assign lvl[EXT_IDX0 + g] = fld_level(fld);
    end

    for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_per
        logic [1:0] fld;
        assign fld               = cfg[PER_BASE + 2*k +: 2];
        assign req[PER_IDX0 + k] = periph_req[k] && (fld != FLD_OFF);
        assign lvl[PER_IDX0 + k] = fld_level(fld);
    end

    irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .lvl   (lvl),
        .mask  (cur_mask),
        .vld   (irq_valid),
        .src   (irq_src),
        .lvl_o (irq_level)
    );

    assign cfg_rdata = cfg;

endmodule

// File: rtl/irq_prio_chk.sv
`timescale 1ns/1ps
module irq_prio_chk #(
    parameter int NUM_PERIPH = 3,
    parameter int REG_W      = 24,
    parameter int IDX_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  soft_clr,
    input logic                  cfg_we,
    input logic [REG_W-1:0]      cfg_wdata,
    input logic [REG_W-1:0]      cfg_rdata,
    input logic [1:0]            cur_mask,
    input logic                  nmi_req,
    input logic                  irq_valid,
    input logic [IDX_W-1:0]      irq_src,
    input logic [1:0]            irq_level
);
    localparam int PER_TOP = 10 + 2 * NUM_PERIPH;

    // R1
    mask_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level == 2'd3 || irq_level >= $past(cur_mask)));

    // R2
    nmi_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> (irq_valid && irq_src == '0 && irq_level == 2'd3));

    // R6
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (cfg_rdata == '0));

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[9:6] == 4'd0 && (cfg_rdata >> PER_TOP) == '0));

    // R4
    write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !soft_clr) |=> (cfg_rdata[5:0] == $past(cfg_wdata[5:0])));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_src == '0 && irq_level == 2'd0));

endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_PERIPH(NUM_PERIPH), .REG_W(REG_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cur_mask  (cur_mask),
    .nmi_req   (nmi_req),
    .irq_valid (irq_valid),
    .irq_src   (irq_src),
    .irq_level (irq_level)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic [1:0]  cur_mask = 2'd0;
    logic        nmi_req = 1'b0;
    logic        ext_a_n = 1'b1;
    logic        ext_b_n = 1'b1;
    logic [2:0]  periph_req = 3'b000;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_src = 3'd0;
    logic        irq_valid;
    logic [2:0]  irq_src;
    logic [1:0]  irq_level;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_clr),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cur_mask   (cur_mask),
        .nmi_req    (nmi_req),
        .ext_a_n    (ext_a_n),
        .ext_b_n    (ext_b_n),
        .periph_req (periph_req),
        .ack_valid  (ack_valid),
        .ack_src    (ack_src),
        .irq_valid  (irq_valid),
        .irq_src    (irq_src),
        .irq_level  (irq_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [23:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step(1);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic chk_out(input string req, input logic v, input logic [2:0] s, input logic [1:0] l);
        chk(req, {26'd0, irq_valid, irq_src, irq_level}, {26'd0, v, s, l});
    endtask

    task automatic t_reset;
        chk("R6 reset clears register", cfg_rdata, 24'h0);
        chk_out("R11 idle outputs after reset", 1'b0, 3'd0, 2'd0);
    endtask

    task automatic t_regs;
        wr_cfg(24'hFFFFFF);
        chk("R5 reserved bits read zero", cfg_rdata, 24'h00FC3F);
        wr_cfg(24'h00A41D);
        chk("R4 field read-back", cfg_rdata, 24'h00A41D);
        wr_cfg(24'h0003C0);
        chk("R5 reserved-only write ignored", cfg_rdata, 24'h0);
    endtask

    task automatic t_clear;
        wr_cfg(24'h00A41D);
        soft_clr = 1'b1; cfg_we = 1'b1; cfg_wdata = 24'h00003F;
        step(1);
        soft_clr = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        chk("R6 soft clear wins over write", cfg_rdata, 24'h0);
        wr_cfg(24'h00A41D);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
        chk("R6 hardware reset clears", cfg_rdata, 24'h0);
    endtask

    task automatic t_mask;
        for (int m = 0; m < 4; m++) begin
            cur_mask = 2'(m);
            for (int l = 0; l < 3; l++) begin
                wr_cfg(24'(l + 1) << 10);
                periph_req = 3'b001;
                step(1);
                if (l >= m) chk_out("R1 level passes mask", 1'b1, 3'd3, 2'(l));
                else        chk_out("R1 level masked", 1'b0, 3'd0, 2'd0);
                periph_req = 3'b000;
            end
            nmi_req = 1'b1;
            step(1);
            chk_out("R2 level 3 never masked", 1'b1, 3'd0, 2'd3);
            nmi_req = 1'b0;
            step(1);
        end
        cur_mask = 2'd0;
    endtask

    task automatic t_disable;
        wr_cfg(24'h0);
        periph_req = 3'b111; ext_a_n = 1'b0; ext_b_n = 1'b0;
        step(2);
        chk_out("R3 disabled sources ignored", 1'b0, 3'd0, 2'd0);
        periph_req = 3'b000; ext_a_n = 1'b1; ext_b_n = 1'b1;
        wr_cfg(24'h000004);
        ext_a_n = 1'b0;
        step(1);
        ext_a_n = 1'b1;
        step(1);
        wr_cfg(24'h000005);
        step(1);
        chk_out("R3 disabled edge not latched", 1'b0, 3'd0, 2'd0);
    endtask

    task automatic t_level;
        wr_cfg(24'h000002);
        ext_a_n = 1'b0;
        step(1);
        chk_out("R7 R10 level low requests next cycle", 1'b1, 3'd1, 2'd1);
        ext_a_n = 1'b1;
        step(1);
        chk_out("R7 level released drops", 1'b0, 3'd0, 2'd0);
    endtask

    task automatic t_edge;
        wr_cfg(24'h000038);
        step(1);
        ext_b_n = 1'b0;
        step(1);
        chk_out("R10 edge not yet visible", 1'b0, 3'd0, 2'd0);
        step(1);
        chk_out("R8 R10 edge pending shown", 1'b1, 3'd2, 2'd2);
        ext_b_n = 1'b1;
        step(1);
        chk_out("R8 pending held after pin high", 1'b1, 3'd2, 2'd2);
        ack_valid = 1'b1; ack_src = 3'd1;
        step(1);
        ack_valid = 1'b0; ack_src = 3'd0;
        step(1);
        chk_out("R8 wrong-index ack ignored", 1'b1, 3'd2, 2'd2);
        ack_valid = 1'b1; ack_src = 3'd2;
        step(1);
        ack_valid = 1'b0; ack_src = 3'd0;
        step(1);
        chk_out("R8 matching ack clears", 1'b0, 3'd0, 2'd0);
    endtask

    task automatic t_prio;
        wr_cfg(24'h00CC12);
        ext_a_n = 1'b0; ext_b_n = 1'b0; periph_req = 3'b101;
        step(1);
        chk_out("R9 highest level, lowest index", 1'b1, 3'd3, 2'd2);
        periph_req = 3'b100;
        step(1);
        chk_out("R9 remaining level 2 source", 1'b1, 3'd5, 2'd2);
        periph_req = 3'b000;
        step(1);
        chk_out("R9 tie A over B", 1'b1, 3'd1, 2'd1);
        nmi_req = 1'b1;
        step(1);
        chk_out("R2 R9 non-maskable on top", 1'b1, 3'd0, 2'd3);
        nmi_req = 1'b0; cur_mask = 2'd3;
        step(1);
        chk_out("R1 mask 3 blocks level 1", 1'b0, 3'd0, 2'd0);
        nmi_req = 1'b1;
        step(1);
        chk_out("R1 mask 3 passes level 3", 1'b1, 3'd0, 2'd3);
        nmi_req = 1'b0; cur_mask = 2'd0; ext_a_n = 1'b1; ext_b_n = 1'b1;
        step(1);
        chk_out("R11 idle after release", 1'b0, 3'd0, 2'd0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_regs;
        t_clear;
        t_mask;
        t_disable;
        t_level;
        t_edge;
        t_prio;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule